// File: doc/BRIEF.md
# Processor/Debug Bus Matrix with Address Routing

This block sits between two bus masters, the processor and a debug access port, and three targets: an external system bus port, an internal private peripheral region and a single-cycle I/O port. A fixed-priority arbiter picks one master per cycle. The winning request is decoded by address and forwarded to exactly one target, and the response is routed back to the master that issued it. The processor always wins a contested cycle, so debug traffic only uses cycles the processor leaves idle.

The private region is the 256 MB window 0xE0000000 to 0xEFFFFFFF. It accepts only word accesses and never reaches the external port. A data access outside that window whose address matches a configured base/mask pair is sent to the I/O port instead of the external port. Processor instruction fetches are never redirected. The handshake is kept simple. A master holds `*_req` and its request fields until `*_done` is asserted in the same cycle as the completion. The external port may stall with `ext_ready`, and the private and I/O targets always complete in the cycle they are selected.

Top module: `busmx_matrix`

## Requirements
- R1: When both masters request and no transfer is in progress, the processor is granted (`cpu_gnt`=1) and the debug port is not (`dbg_gnt`=0).
- R2: A word access (size code 2'b10) to 0xE0000000–0xEFFFFFFF asserts `prv_valid`, never `ext_valid`, and completes in the same cycle.
- R3: An access below 0xE0000000 or above 0xEFFFFFFF that is not redirected asserts `ext_valid` with the master's address on `ext_addr`.
- R4: A byte (2'b00) or halfword (2'b01) access to 0xE0000000–0xEFFFFFFF completes in the same cycle with `*_err`=1 and asserts no target valid.
- R5: A data access from either master outside the private window with `(addr & IO_MASK) == IO_BASE` (default 0x5xxxxxxx) asserts `io_valid` instead of `ext_valid` and completes in the same cycle.
- R6: A processor instruction fetch (`cpu_data`=0) is never sent to the I/O port, even when its address matches the I/O window.
- R7: A waiting debug request is granted in the first cycle the processor does not request. A granted transfer that is stalled by `ext_ready`=0 keeps its grant even if the other master starts requesting.
- R8: Only the granted master sees `*_done`. Its `*_rdata` carries the selected target's read data, and an external error (`ext_err` with `ext_ready`) appears as `*_err`.
- R9: While `rst_n` is low, no grant and no target valid is asserted, whatever the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request |
| cpu_addr | input | AW | Processor address |
| cpu_size | input | 2 | Processor size: 00 byte, 01 half, 10 word |
| cpu_write | input | 1 | Processor write |
| cpu_data | input | 1 | 1 = data access, 0 = instruction fetch |
| cpu_wdata | input | DW | Processor write data |
| cpu_gnt | output | 1 | Processor granted this cycle |
| cpu_done | output | 1 | Processor transfer completes this cycle |
| cpu_err | output | 1 | Processor transfer completes with error |
| cpu_rdata | output | DW | Processor read data |
| dbg_req | input | 1 | Debug request (always data) |
| dbg_addr | input | AW | Debug address |
| dbg_size | input | 2 | Debug size |
| dbg_write | input | 1 | Debug write |
| dbg_wdata | input | DW | Debug write data |
| dbg_gnt | output | 1 | Debug granted this cycle |
| dbg_done | output | 1 | Debug transfer completes this cycle |
| dbg_err | output | 1 | Debug transfer completes with error |
| dbg_rdata | output | DW | Debug read data |
| ext_valid | output | 1 | External port transfer valid |
| ext_addr | output | AW | External address |
| ext_size | output | 2 | External size |
| ext_write | output | 1 | External write |
| ext_fetch | output | 1 | External transfer is an instruction fetch |
| ext_wdata | output | DW | External write data |
| ext_ready | input | 1 | External transfer complete |
| ext_err | input | 1 | External error response |
| ext_rdata | input | DW | External read data |
| prv_valid | output | 1 | Private region transfer valid |
| prv_addr | output | AW | Private region address |
| prv_write | output | 1 | Private region write |
| prv_wdata | output | DW | Private region write data |
| prv_rdata | input | DW | Private region read data |
| io_valid | output | 1 | I/O port transfer valid |
| io_addr | output | AW | I/O port address |
| io_size | output | 2 | I/O port size |
| io_write | output | 1 | I/O port write |
| io_wdata | output | DW | I/O port write data |
| io_rdata | input | DW | I/O port read data |

## Verification
The assertions assume that each master keeps its request and address steady from the cycle it asserts `*_req` until the cycle it sees `*_done`. They also assume that the external target eventually raises `ext_ready`. The bench keeps to this contract in three ways. It raises every request just after a falling edge. It drops each request only after the completion has been observed. In the stall and contention tests, it holds the waiting debug request unchanged across the cycles it is kept waiting. Size codes 2'b11 are never driven, because the block defines no meaning for them.

// File: rtl/busmx_pkg.sv
// Package: shared encodings for the bus matrix.
// Assumes: size codes 00 byte, 01 halfword, 10 word; 11 unused.
package busmx_pkg;
    typedef enum logic [1:0] {
        TGT_EXT = 2'd0,
        TGT_PRV = 2'd1,
        TGT_IO  = 2'd2,
        TGT_ERR = 2'd3
    } tgt_e;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;
endpackage

// File: rtl/busmx_arbiter.sv
// Fixed-priority arbiter with transfer lock.
// Lower index wins a contested cycle. Once a master is granted and its
// transfer has not completed, the grant stays with it.
// Assumes: a granted master holds req until done.
module busmx_arbiter #(
    parameter int NM = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NM-1:0] req,
    input  logic          done,
    output logic [NM-1:0] gnt
);
    logic [NM-1:0] lock_q;
    logic [NM-1:0] prio;

    // Pick the lowest-index requester.
    always_comb begin
        prio = '0;
        for (int i = 0; i < NM; i++) begin
            if (req[i] && (prio == '0)) prio[i] = 1'b1;
        end
    end

    // A locked owner keeps the bus; otherwise priority decides.
    always_comb begin
        if (!rst_n)          gnt = '0;
        else if (|lock_q)    gnt = lock_q & req;
        else                 gnt = prio;
    end

    // Remember an owner whose transfer did not finish this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    lock_q <= '0;
        else if (done) lock_q <= '0;
        else           lock_q <= gnt;
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R1
    AST_LOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q == '0 && req[0]) |-> gnt[0]); // R1
    AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt) && !done) |=> ((gnt & req) == ($past(gnt) & req))); // R7
endmodule

// File: rtl/busmx_decode.sv
// Address decoder: classifies one request into a target.
// The private window takes precedence over the I/O redirect. The redirect
// applies only to data accesses and only when IO_EN is set.
// Assumes: size is a legal code (00/01/10).
module busmx_decode
    import busmx_pkg::*;
#(
    parameter int          AW       = 32,
    parameter logic [AW-1:0] PRV_BASE = 32'hE000_0000,
    parameter logic [AW-1:0] PRV_MASK = 32'hF000_0000,
    parameter bit          IO_EN    = 1'b1,
    parameter logic [AW-1:0] IO_BASE  = 32'h5000_0000,
    parameter logic [AW-1:0] IO_MASK  = 32'hF000_0000
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    input  logic          is_data,
    output tgt_e          tgt
);
    logic in_prv;
    logic io_hit;

    assign in_prv = ((addr & PRV_MASK) == PRV_BASE);

    generate
        if (IO_EN) begin : g_io
            assign io_hit = is_data && ((addr & IO_MASK) == IO_BASE);
        end else begin : g_no_io
            assign io_hit = 1'b0;
        end
    endgenerate

    // Choose the target: private (word only), I/O redirect, else external.
    always_comb begin
        if (in_prv)      tgt = (size == SZ_WORD) ? TGT_PRV : TGT_ERR;
        else if (io_hit) tgt = TGT_IO;
        else             tgt = TGT_EXT;
    end
endmodule

// File: rtl/busmx_matrix.sv
// Two-master bus matrix: the processor (index 0) and the debug port (index 1)
// share three targets. The selected request is forwarded combinationally;
// responses return in the cycle the target completes.
// Assumes: masters hold request fields until done; private and I/O
// targets are zero-wait; the external port signals completion on ext_ready.
module busmx_matrix
    import busmx_pkg::*;
#(
    parameter int            AW       = 32,
    parameter int            DW       = 32,
    parameter logic [AW-1:0] PRV_BASE = 32'hE000_0000,
    parameter logic [AW-1:0] PRV_MASK = 32'hF000_0000,
    parameter bit            IO_EN    = 1'b1,
    parameter logic [AW-1:0] IO_BASE  = 32'h5000_0000,
    parameter logic [AW-1:0] IO_MASK  = 32'hF000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic [AW-1:0] cpu_addr,
    input  logic [1:0]    cpu_size,
    input  logic          cpu_write,
    input  logic          cpu_data,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_gnt,
    output logic          cpu_done,
    output logic          cpu_err,
    output logic [DW-1:0] cpu_rdata,
    input  logic          dbg_req,
    input  logic [AW-1:0] dbg_addr,
    input  logic [1:0]    dbg_size,
    input  logic          dbg_write,
    input  logic [DW-1:0] dbg_wdata,
    output logic          dbg_gnt,
    output logic          dbg_done,
    output logic          dbg_err,
    output logic [DW-1:0] dbg_rdata,
    output logic          ext_valid,
    output logic [AW-1:0] ext_addr,
    output logic [1:0]    ext_size,
    output logic          ext_write,
    output logic          ext_fetch,
    output logic [DW-1:0] ext_wdata,
    input  logic          ext_ready,
    input  logic          ext_err,
    input  logic [DW-1:0] ext_rdata,
    output logic          prv_valid,
    output logic [AW-1:0] prv_addr,
    output logic          prv_write,
    output logic [DW-1:0] prv_wdata,
    input  logic [DW-1:0] prv_rdata,
    output logic          io_valid,
    output logic [AW-1:0] io_addr,
    output logic [1:0]    io_size,
    output logic          io_write,
    output logic [DW-1:0] io_wdata,
    input  logic [DW-1:0] io_rdata
);
    localparam int NM    = 2;
    localparam int M_CPU = 0;
    localparam int M_DBG = 1;

    logic [NM-1:0] req;
    logic [NM-1:0] gnt;
    logic          any_gnt;
    logic [AW-1:0] act_addr;
    logic [1:0]    act_size;
    logic          act_write;
    logic          act_data;
    logic [DW-1:0] act_wdata;
    logic [DW-1:0] act_rdata;
    logic          act_done;
    logic          act_err;
    tgt_e          tgt;

    assign req = {dbg_req, cpu_req};

    busmx_arbiter #(.NM(NM)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .done  (act_done),
        .gnt   (gnt)
    );

    assign any_gnt = |gnt;
    assign cpu_gnt = gnt[M_CPU];
    assign dbg_gnt = gnt[M_DBG];

    // Select the granted master's request fields.
    always_comb begin
        if (gnt[M_CPU]) begin
            act_addr  = cpu_addr;
            act_size  = cpu_size;
            act_write = cpu_write;
            act_data  = cpu_data;
            act_wdata = cpu_wdata;
        end else begin
            act_addr  = dbg_addr;
            act_size  = dbg_size;
            act_write = dbg_write;
            act_data  = 1'b1;
            act_wdata = dbg_wdata;
        end
    end

    busmx_decode #(
        .AW       (AW),
        .PRV_BASE (PRV_BASE),
        .PRV_MASK (PRV_MASK),
        .IO_EN    (IO_EN),
        .IO_BASE  (IO_BASE),
        .IO_MASK  (IO_MASK)
    ) u_dec (
        .addr    (act_addr),
        .size    (act_size),
        .is_data (act_data),
        .tgt     (tgt)
    );

    // Forward the request to exactly one target.
    always_comb begin
        ext_valid = any_gnt && (tgt == TGT_EXT);
        prv_valid = any_gnt && (tgt == TGT_PRV);
        io_valid  = any_gnt && (tgt == TGT_IO);
        ext_addr  = act_addr;
        ext_size  = act_size;
        ext_write = act_write;
        ext_fetch = !act_data;
        ext_wdata = act_wdata;
        prv_addr  = act_addr;
        prv_write = act_write;
        prv_wdata = act_wdata;
        io_addr   = act_addr;
        io_size   = act_size;
        io_write  = act_write;
        io_wdata  = act_wdata;
    end

    // Build the completion, error and read data of the selected target.
    always_comb begin
        act_done  = any_gnt && ((tgt == TGT_EXT) ? ext_ready : 1'b1);
        act_err   = any_gnt && ((tgt == TGT_ERR) ||
                                ((tgt == TGT_EXT) && ext_ready && ext_err));
        unique case (tgt)
            TGT_EXT: act_rdata = ext_rdata;
            TGT_PRV: act_rdata = prv_rdata;
            TGT_IO:  act_rdata = io_rdata;
            default: act_rdata = '0;
        endcase
    end

    // Return the response to the granted master only.
    always_comb begin
        cpu_done  = gnt[M_CPU] && act_done;
        cpu_err   = gnt[M_CPU] && act_err;
        cpu_rdata = gnt[M_CPU] ? act_rdata : '0;
        dbg_done  = gnt[M_DBG] && act_done;
        dbg_err   = gnt[M_DBG] && act_err;
        dbg_rdata = gnt[M_DBG] ? act_rdata : '0;
    end

    AST_PRV_NEVER_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid |-> ((ext_addr & PRV_MASK) != PRV_BASE)); // R2
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_valid, prv_valid, io_valid})); // R3
    AST_ERR_NO_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_err || dbg_err) |-> (!prv_valid && !io_valid)); // R4
    AST_FETCH_NOT_IO: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_gnt && !cpu_data) |-> !io_valid); // R6
    AST_DBG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && !dbg_done) |=> (dbg_req && $stable(dbg_addr))); // R7
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_done && dbg_done)); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> !(cpu_gnt || dbg_gnt || ext_valid || prv_valid || io_valid)); // R9
endmodule

// File: tb/busmx_matrix_tb.sv
module busmx_matrix_tb;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cpu_req, cpu_write, cpu_data;
    logic [AW-1:0] cpu_addr;
    logic [1:0]    cpu_size;
    logic [DW-1:0] cpu_wdata;
    logic          cpu_gnt, cpu_done, cpu_err;
    logic [DW-1:0] cpu_rdata;
    logic          dbg_req, dbg_write;
    logic [AW-1:0] dbg_addr;
    logic [1:0]    dbg_size;
    logic [DW-1:0] dbg_wdata;
    logic          dbg_gnt, dbg_done, dbg_err;
    logic [DW-1:0] dbg_rdata;
    logic          ext_valid, ext_write, ext_fetch, ext_ready, ext_err;
    logic [AW-1:0] ext_addr;
    logic [1:0]    ext_size;
    logic [DW-1:0] ext_wdata, ext_rdata;
    logic          prv_valid, prv_write;
    logic [AW-1:0] prv_addr;
    logic [DW-1:0] prv_wdata, prv_rdata;
    logic          io_valid, io_write;
    logic [AW-1:0] io_addr;
    logic [1:0]    io_size;
    logic [DW-1:0] io_wdata, io_rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    busmx_matrix u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
        .cpu_write(cpu_write), .cpu_data(cpu_data), .cpu_wdata(cpu_wdata),
        .cpu_gnt(cpu_gnt), .cpu_done(cpu_done), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
        .dbg_req(dbg_req), .dbg_addr(dbg_addr), .dbg_size(dbg_size),
        .dbg_write(dbg_write), .dbg_wdata(dbg_wdata),
        .dbg_gnt(dbg_gnt), .dbg_done(dbg_done), .dbg_err(dbg_err), .dbg_rdata(dbg_rdata),
        .ext_valid(ext_valid), .ext_addr(ext_addr), .ext_size(ext_size),
        .ext_write(ext_write), .ext_fetch(ext_fetch), .ext_wdata(ext_wdata),
        .ext_ready(ext_ready), .ext_err(ext_err), .ext_rdata(ext_rdata),
        .prv_valid(prv_valid), .prv_addr(prv_addr), .prv_write(prv_write),
        .prv_wdata(prv_wdata), .prv_rdata(prv_rdata),
        .io_valid(io_valid), .io_addr(io_addr), .io_size(io_size),
        .io_write(io_write), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    // Vector: {master(1: 0 cpu, 1 dbg), addr(32), size(2), data(1), target(2: 0 ext,1 prv,2 io,3 err)}
    localparam int NV = 12;
    localparam logic [37:0] VEC [NV] = '{
        {1'b0, 32'h2000_0000, 2'b10, 1'b1, 2'd0},   // R3 plain external
        {1'b0, 32'hE000_E100, 2'b10, 1'b1, 2'd1},   // R2 private word
        {1'b0, 32'hDFFF_FFFC, 2'b10, 1'b1, 2'd0},   // R3 just below window
        {1'b0, 32'hEFFF_FFFC, 2'b10, 1'b1, 2'd1},   // R2 top of window
        {1'b0, 32'hF000_0000, 2'b10, 1'b1, 2'd0},   // R3 just above window
        {1'b0, 32'hE000_0000, 2'b00, 1'b1, 2'd3},   // R4 byte in window
        {1'b1, 32'hE000_ED00, 2'b01, 1'b1, 2'd3},   // R4 debug halfword
        {1'b0, 32'h5000_0010, 2'b00, 1'b1, 2'd2},   // R5 cpu data redirect
        {1'b1, 32'h5FFF_FFF0, 2'b10, 1'b1, 2'd2},   // R5 debug redirect
        {1'b0, 32'h5000_0010, 2'b10, 1'b0, 2'd0},   // R6 fetch not redirected
        {1'b1, 32'hE000_0004, 2'b10, 1'b1, 2'd1},   // R2 debug private
        {1'b0, 32'h0000_0100, 2'b10, 1'b0, 2'd0}    // R3 fetch external
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cpu_req = 1'b0; dbg_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cpu_req = 1'b1; cpu_addr = 32'h2000_0000; cpu_size = 2'b10; cpu_write = 1'b0;
        cpu_data = 1'b1; cpu_wdata = 32'h1111_1111;
        dbg_req = 1'b0; dbg_addr = '0; dbg_size = 2'b10; dbg_write = 1'b1;
        dbg_wdata = 32'h2222_2222;
        ext_ready = 1'b1; ext_err = 1'b0;
        ext_rdata = 32'hAAAA_0001; prv_rdata = 32'hBBBB_0002; io_rdata = 32'hCCCC_0003;

        // R9: reset holds everything quiet even with a request present
        repeat (2) @(negedge clk);
        #2;
        chk(!cpu_gnt && !ext_valid && !prv_valid && !io_valid, "R9 reset quiet",
            {cpu_gnt, ext_valid, prv_valid, io_valid}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle();

        // Table walk: one master alone per vector
        for (int v = 0; v < NV; v++) begin
            logic        m;
            logic [1:0]  t;
            logic [2:0]  exp_v;
            @(negedge clk);
            m = VEC[v][37];
            t = VEC[v][1:0];
            if (m == 1'b0) begin
                cpu_req = 1'b1; cpu_addr = VEC[v][36:5]; cpu_size = VEC[v][4:3];
                cpu_data = VEC[v][2];
            end else begin
                dbg_req = 1'b1; dbg_addr = VEC[v][36:5]; dbg_size = VEC[v][4:3];
            end
            exp_v = (t == 2'd0) ? 3'b100 : (t == 2'd1) ? 3'b010 : (t == 2'd2) ? 3'b001 : 3'b000;
            #2;
            chk({ext_valid, prv_valid, io_valid} == exp_v, "R2/R3/R4/R5/R6 target select",
                {ext_valid, prv_valid, io_valid}, exp_v);
            if (m == 1'b0)
                chk(cpu_done && (cpu_err == (t == 2'd3)), "R4 cpu done/err",
                    {cpu_done, cpu_err}, {1'b1, t == 2'd3});
            else
                chk(dbg_done && (dbg_err == (t == 2'd3)), "R4 dbg done/err",
                    {dbg_done, dbg_err}, {1'b1, t == 2'd3});
            if (t == 2'd0)
                chk(ext_addr == VEC[v][36:5], "R3 ext address", ext_addr, VEC[v][36:5]);
            @(negedge clk);
            idle();
        end

        // R1: contention, processor wins; debug waits with stable request
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = 32'hE000_0010; cpu_size = 2'b10; cpu_data = 1'b1;
        dbg_req = 1'b1; dbg_addr = 32'h3000_0000; dbg_size = 2'b10;
        #2;
        chk(cpu_gnt && !dbg_gnt, "R1 processor first", {cpu_gnt, dbg_gnt}, 2'b10);
        chk(cpu_rdata == 32'hBBBB_0002 && !dbg_done, "R8 private rdata to cpu only",
            cpu_rdata, 32'hBBBB_0002);
        // R7: processor drops, debug granted in that cycle
        @(negedge clk);
        cpu_req = 1'b0;
        #2;
        chk(dbg_gnt && dbg_done && ext_valid, "R7 debug granted when cpu idle",
            {dbg_gnt, dbg_done, ext_valid}, 3'b111);
        chk(dbg_rdata == 32'hAAAA_0001 && cpu_rdata == '0, "R8 ext rdata to dbg only",
            dbg_rdata, 32'hAAAA_0001);
        @(negedge clk);
        idle();

        // R7: stalled debug transfer keeps its grant against the processor
        @(negedge clk);
        ext_ready = 1'b0;
        dbg_req = 1'b1; dbg_addr = 32'h4000_0040;
        #2;
        chk(dbg_gnt && !dbg_done, "R7 debug stalled", {dbg_gnt, dbg_done}, 2'b10);
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = 32'h2000_0004; cpu_data = 1'b1;
        #2;
        chk(dbg_gnt && !cpu_gnt && !cpu_done, "R7 lock holds against cpu",
            {dbg_gnt, cpu_gnt}, 2'b10);
        @(negedge clk);
        ext_ready = 1'b1; ext_err = 1'b1;
        #2;
        chk(dbg_done && dbg_err, "R8 ext error to debug", {dbg_done, dbg_err}, 2'b11);
        @(negedge clk);
        dbg_req = 1'b0; ext_err = 1'b0;
        #2;
        chk(cpu_gnt && cpu_done && !cpu_err, "R1 cpu after lock release",
            {cpu_gnt, cpu_done, cpu_err}, 3'b110);
        @(negedge clk);
        idle();

        // R4: rejected private access reaches no target and leaves none touched next cycle
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = 32'hE000_E400; cpu_size = 2'b01; cpu_write = 1'b1;
        #2;
        chk(cpu_err && !prv_valid && !ext_valid && !io_valid, "R4 halfword write rejected",
            {cpu_err, prv_valid, ext_valid, io_valid}, 4'b1000);
        @(negedge clk);
        idle();
        #2;
        chk(!prv_valid && !cpu_gnt, "R4 no residual access", {prv_valid, cpu_gnt}, 0);

        // R9: reset again in mid traffic
        @(negedge clk);
        rst_n = 1'b0; dbg_req = 1'b1; dbg_addr = 32'h5000_0000;
        #2;
        chk(!dbg_gnt && !io_valid, "R9 reset gates debug", {dbg_gnt, io_valid}, 0);
        @(negedge clk);
        idle();
        rst_n = 1'b1;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule